// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps recently used virtual-to-physical page translations in a small fully associative store. Any translation may sit in any slot. Each slot is tagged with the address space number of the process that owns it. A process switch therefore only changes the number presented on the lookup side, and nothing has to be flushed. Pages are 8 KB, so the low 13 bits of an address pass through untranslated. The upper bits are replaced by the stored physical page number.

A lookup is purely combinational. The virtual address, the current address space number and the kind of access go in, and one of three outcomes comes out: a hit with a physical address, a permission fault, or a miss. On a miss, outside logic walks the page table and writes the answer back through the fill port, and the new slot takes effect at the next clock edge. The fill goes into the first free slot. When the store is full it replaces a slot chosen by a rotating pointer. A single-cycle flush input drops every translation.

Top module: `tlb_asn_xlate`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss.
- R2: A lookup matches a slot only if the slot is valid and both the virtual page number (address bits above bit 12) and the address space number are equal. The same page under another address space number does not match.
- R3: When a lookup hits, the physical address is the stored physical page number followed by the lookup's address bits 12..0. When it does not hit, the physical address is zero.
- R4: Fill permission bits are bit 0 read, bit 1 write and bit 2 execute. Access codes are 00 read, 01 write, 10 execute and 11 reserved, and the reserved code is never permitted. A matching slot that permits the access gives a hit. A matching slot that does not permit it gives a fault with no hit and a zero address.
- R5: In every cycle exactly one of hit, fault and miss is high.
- R6: A fill changes nothing in the cycle it is presented. The lookup result changes only after the next rising clock edge.
- R7: A fill whose page number and address space number equal those of a valid slot overwrites that slot. No other slot is touched and the replacement pointer does not move.
- R8: Otherwise, if any slot is empty, the fill goes into the empty slot with the lowest index.
- R9: Otherwise the fill replaces the slot that the replacement pointer names. The pointer is 0 after reset and advances by one, wrapping around, only on such a replacement. A flush leaves the pointer unchanged.
- R10: A flush empties every slot at the next rising edge. A fill presented in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Address space number of the current process |
| lk_acc | input | 2 | Access code: 00 read, 01 write, 10 execute, 11 reserved |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_fault | output | 1 | Translation found but access not permitted |
| lk_miss | output | 1 | No matching translation |
| lk_pa | output | PA_W | Physical address on a hit, zero otherwise |
| fl_en | input | 1 | Write a translation at the next edge |
| fl_vpn | input | VA_W-PAGE_BITS | Virtual page number to store |
| fl_asn | input | ASN_W | Address space number to store |
| fl_ppn | input | PA_W-PAGE_BITS | Physical page number to store |
| fl_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| inv_all | input | 1 | Empty all slots at the next edge |

## Verification
The bench uses four slots and 7-bit page numbers. After each phase it sweeps every page number against every address space number and every access code, and compares the outcome and address with a model of where each fill must have landed. The fills are chosen to tell the cases apart. One fill reuses a page number under a second address space number, which separates matching on both keys from matching on the page alone. Permission masks cover read-only, write-only, mixed and full, which separates the per-code permission rules. A refill of an existing pair, an eviction while full, and refilling after a flush with the pointer left mid-way separate overwrite, lowest-free and rotating placement: each predicts a different surviving set. Single-cycle probes also check that a fill is not visible in its own cycle, and that a fill presented together with a flush is lost.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int PERM_W = 3;

  // permission bit order: 0 read, 1 write, 2 execute
  function automatic logic acc_allowed(input logic [1:0] acc,
                                       input logic [PERM_W-1:0] perm);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = perm[0];
      ACC_STORE: ok = perm[1];
      ACC_FETCH: ok = perm[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_asn_cam.sv
module tlb_asn_cam #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 19,
  parameter int ASN_W   = 8,
  parameter int PERM_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_all,
  input  logic               wr_en,
  input  logic [ENTRIES-1:0] wr_sel,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASN_W-1:0]   wr_asn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASN_W-1:0]   lk_asn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fl_match,
  output logic [ENTRIES-1:0] valid_q,
  output logic [PPN_W-1:0]   rd_ppn,
  output logic [PERM_W-1:0]  rd_perm
);

  logic [ENTRIES-1:0] valid_d;
  logic [PPN_W-1:0]   ppn_gated  [ENTRIES];
  logic [PERM_W-1:0]  perm_gated [ENTRIES];

  always_comb begin
    valid_d = valid_q;
    if (inv_all)    valid_d = '0;
    else if (wr_en) valid_d = valid_q | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [VPN_W-1:0]  vpn_r;
    logic [ASN_W-1:0]  asn_r;
    logic [PPN_W-1:0]  ppn_r;
    logic [PERM_W-1:0] perm_r;
    logic              load_en;

    assign load_en = wr_en && !inv_all && wr_sel[e];

    always_ff @(posedge clk) begin
      if (load_en) begin
        vpn_r  <= wr_vpn;
        asn_r  <= wr_asn;
        ppn_r  <= wr_ppn;
        perm_r <= wr_perm;
      end
    end

    assign lk_match[e]   = valid_q[e] && (vpn_r == lk_vpn) && (asn_r == lk_asn);
    assign fl_match[e]   = valid_q[e] && (vpn_r == wr_vpn) && (asn_r == wr_asn);
    assign ppn_gated[e]  = lk_match[e] ? ppn_r  : '0;
    assign perm_gated[e] = lk_match[e] ? perm_r : '0;
  end

  always_comb begin
    rd_ppn  = '0;
    rd_perm = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      rd_ppn  = rd_ppn  | ppn_gated[e];
      rd_perm = rd_perm | perm_gated[e];
    end
  end

endmodule

// File: rtl/tlb_asn_victim.sv
module tlb_asn_victim #(
  parameter int ENTRIES = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] fl_match,
  input  logic [ENTRIES-1:0] valid_q,
  output logic [ENTRIES-1:0] wr_sel
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [ENTRIES-1:0] free_vec, free_low, ptr_oh;
  logic               same_any, free_any, advance;

  assign free_vec = ~valid_q;
  assign free_low = free_vec & (~free_vec + 1'b1);
  assign same_any = |fl_match;
  assign free_any = |free_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) ptr_oh[i] = (ptr_q == IDX_W'(i));
  end

  always_comb begin
    if (same_any)      wr_sel = fl_match;
    else if (free_any) wr_sel = free_low;
    else               wr_sel = ptr_oh;
  end

  assign advance = fill_go && !same_any && !free_any;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/tlb_asn_xlate.sv
module tlb_asn_xlate
  import tlb_asn_pkg::*;
#(
  parameter int ENTRIES   = 128,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int ASN_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VA_W-1:0]           lk_va,
  input  logic [ASN_W-1:0]          lk_asn,
  input  logic [1:0]                lk_acc,
  output logic                      lk_hit,
  output logic                      lk_fault,
  output logic                      lk_miss,
  output logic [PA_W-1:0]           lk_pa,
  input  logic                      fl_en,
  input  logic [VA_W-PAGE_BITS-1:0] fl_vpn,
  input  logic [ASN_W-1:0]          fl_asn,
  input  logic [PA_W-PAGE_BITS-1:0] fl_ppn,
  input  logic [2:0]                fl_perm,
  input  logic                      inv_all
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [ENTRIES-1:0] lk_match, fl_match, valid_q, wr_sel;
  logic [PPN_W-1:0]   rd_ppn;
  logic [PERM_W-1:0]  rd_perm;
  logic               fill_go, found, allowed;

  assign fill_go = fl_en && !inv_all;

  tlb_asn_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .ASN_W(ASN_W), .PERM_W(PERM_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .wr_en(fill_go), .wr_sel(wr_sel),
    .wr_vpn(fl_vpn), .wr_asn(fl_asn), .wr_ppn(fl_ppn), .wr_perm(fl_perm),
    .lk_vpn(lk_va[VA_W-1:PAGE_BITS]), .lk_asn(lk_asn),
    .lk_match(lk_match), .fl_match(fl_match), .valid_q(valid_q),
    .rd_ppn(rd_ppn), .rd_perm(rd_perm)
  );

  tlb_asn_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_go(fill_go),
    .fl_match(fl_match), .valid_q(valid_q), .wr_sel(wr_sel)
  );

  assign found   = |lk_match;
  assign allowed = acc_allowed(lk_acc, rd_perm);

  assign lk_hit   = found && allowed;
  assign lk_fault = found && !allowed;
  assign lk_miss  = !found;
  assign lk_pa    = lk_hit ? {rd_ppn, lk_va[PAGE_BITS-1:0]} : '0;

endmodule

// File: rtl/tlb_asn_xlate_chk.sv
module tlb_asn_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int ASN_W     = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [VA_W-1:0]           lk_va,
  input logic [ASN_W-1:0]          lk_asn,
  input logic [1:0]                lk_acc,
  input logic                      lk_hit,
  input logic                      lk_fault,
  input logic                      lk_miss,
  input logic [PA_W-1:0]           lk_pa,
  input logic                      fl_en,
  input logic [VA_W-PAGE_BITS-1:0] fl_vpn,
  input logic [ASN_W-1:0]          fl_asn,
  input logic                      inv_all
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_fault, lk_miss}) == 1); // R5

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]); // R3

  AST_PA_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pa == '0); // R3

  AST_RSVD_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_acc == 2'b11 |-> !lk_hit); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) |-> lk_miss); // R10

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fl_en && !inv_all) &&
     lk_va[VA_W-1:PAGE_BITS] == $past(fl_vpn) && lk_asn == $past(fl_asn))
    |-> !lk_miss); // R6

endmodule

bind tlb_asn_xlate tlb_asn_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ASN_W(ASN_W)
) u_chk (.*);

// File: tb/tb_tlb_asn_xlate.sv
module tb_tlb_asn_xlate;

  localparam int N    = 4;
  localparam int VA_W = 20;
  localparam int PA_W = 20;
  localparam int PB   = 13;
  localparam int AW   = 2;
  localparam int VW   = VA_W - PB;
  localparam int PW   = PA_W - PB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [VA_W-1:0] lk_va;
  logic [AW-1:0] lk_asn;
  logic [1:0]    lk_acc;
  logic          lk_hit, lk_fault, lk_miss;
  logic [PA_W-1:0] lk_pa;
  logic          fl_en;
  logic [VW-1:0] fl_vpn;
  logic [AW-1:0] fl_asn;
  logic [PW-1:0] fl_ppn;
  logic [2:0]    fl_perm;
  logic          inv_all;

  always #2.5 clk = ~clk;

  tlb_asn_xlate #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .ASN_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asn(lk_asn), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asn(fl_asn), .fl_ppn(fl_ppn),
    .fl_perm(fl_perm), .inv_all(inv_all)
  );

  int tests = 0;
  int fails = 0;

  // model of the slots, filled by the placement rules
  logic          m_v    [N];
  logic [VW-1:0] m_vpn  [N];
  logic [AW-1:0] m_asn  [N];
  logic [PW-1:0] m_ppn  [N];
  logic [2:0]    m_perm [N];
  int            m_ptr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit perm_ok(input logic [1:0] acc, input logic [2:0] p);
    case (acc)
      2'b00:   return p[0];
      2'b01:   return p[1];
      2'b10:   return p[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                            input logic [PW-1:0] p, input logic [2:0] pm);
    int slot = -1;
    for (int i = 0; i < N; i++) if (slot < 0 && m_v[i] && m_vpn[i] == v && m_asn[i] == a) slot = i;
    if (slot < 0) for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_v[slot] = 1'b1; m_vpn[slot] = v; m_asn[slot] = a; m_ppn[slot] = p; m_perm[slot] = pm;
  endtask

  task automatic do_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                         input logic [PW-1:0] p, input logic [2:0] pm);
    @(negedge clk);
    fl_en = 1'b1; fl_vpn = v; fl_asn = a; fl_ppn = p; fl_perm = pm;
    @(negedge clk);
    fl_en = 1'b0;
    model_fill(v, a, p, pm);
  endtask

  task automatic probe(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [1:0] acc);
    lk_va = {v, 13'h0a5}; lk_asn = a; lk_acc = acc;
    #1;
  endtask

  // every page x every asn x every access code
  task automatic sweep(input string mtag);
    for (int v = 0; v < (1 << VW); v++)
      for (int a = 0; a < (1 << AW); a++)
        for (int c = 0; c < 4; c++) begin
          logic [PB-1:0] off;
          int sl;
          bit e_found, e_hit;
          logic [PA_W-1:0] e_pa;
          off = PB'((v * 37 + a * 11 + c * 1000) & 13'h1fff);
          lk_va = {VW'(v), off}; lk_asn = AW'(a); lk_acc = 2'(c);
          #1;
          sl = -1;
          for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == VW'(v) && m_asn[i] == AW'(a)) sl = i;
          e_found = (sl >= 0);
          e_hit   = e_found && perm_ok(2'(c), m_perm[sl < 0 ? 0 : sl]);
          e_pa    = e_hit ? {m_ppn[sl], off} : '0;
          if (lk_miss != !e_found)
            chk(0, mtag, "miss", 32'(lk_miss), 32'(!e_found));
          else if (lk_hit != e_hit || lk_fault != (e_found && !e_hit))
            chk(0, "R4", "hit/fault", {30'd0, lk_hit, lk_fault}, {30'd0, e_hit, e_found && !e_hit});
          else if (lk_pa != e_pa)
            chk(0, "R3", "pa", 32'(lk_pa), 32'(e_pa));
          else
            chk($countones({lk_hit, lk_fault, lk_miss}) == 1, "R5", "one outcome",
                {29'd0, lk_hit, lk_fault, lk_miss}, 32'd1);
        end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inv_all = 1'b0; fl_en = 1'b0;
    fl_vpn = '0; fl_asn = '0; fl_ppn = '0; fl_perm = '0;
    lk_va = '0; lk_asn = '0; lk_acc = '0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    sweep("R1");

    // R6: fill invisible in its own cycle, visible after edge
    @(negedge clk);
    fl_en = 1'b1; fl_vpn = 7'd5; fl_asn = 2'd1; fl_ppn = 7'h11; fl_perm = 3'b001;
    probe(7'd5, 2'd1, 2'b00);
    chk(lk_miss === 1'b1, "R6", "same-cycle miss", 32'(lk_miss), 32'd1);
    @(negedge clk);
    fl_en = 1'b0;
    model_fill(7'd5, 2'd1, 7'h11, 3'b001);
    probe(7'd5, 2'd1, 2'b00);
    chk(lk_hit === 1'b1, "R6", "hit after edge", 32'(lk_hit), 32'd1);

    // fill to full; same page under a second asn (R2)
    do_fill(7'h40, 2'd1, 7'h22, 3'b110);
    do_fill(7'd5,  2'd2, 7'h33, 3'b111);
    do_fill(7'h7f, 2'd3, 7'h44, 3'b010);
    sweep("R2");

    // R9: full, pointer 0 -> slot 0 (page 5 asn 1) evicted
    do_fill(7'd9, 2'd0, 7'h55, 3'b101);
    probe(7'd5, 2'd1, 2'b00);
    chk(lk_miss === 1'b1, "R9", "slot0 evicted", 32'(lk_miss), 32'd1);
    sweep("R9");

    // R7: refill existing pair overwrites in place, pointer stays 1
    do_fill(7'h40, 2'd1, 7'h66, 3'b001);
    probe(7'h40, 2'd1, 2'b00);
    chk(lk_pa === {7'h66, 13'h0a5}, "R7", "overwritten ppn", 32'(lk_pa), 32'({7'h66, 13'h0a5}));
    probe(7'd9, 2'd0, 2'b10);
    chk(lk_hit === 1'b1, "R7", "neighbour kept", 32'(lk_hit), 32'd1);
    do_fill(7'h20, 2'd0, 7'h77, 3'b111);
    probe(7'h40, 2'd1, 2'b00);
    chk(lk_miss === 1'b1, "R9", "slot1 evicted", 32'(lk_miss), 32'd1);
    probe(7'd5, 2'd2, 2'b01);
    chk(lk_hit === 1'b1, "R9", "slot2 kept", 32'(lk_hit), 32'd1);
    sweep("R7");

    // R10: flush empties everything
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    sweep("R10");

    // R10: fill with flush in same cycle is dropped
    do_fill(7'd1, 2'd0, 7'h01, 3'b111);
    @(negedge clk);
    inv_all = 1'b1; fl_en = 1'b1; fl_vpn = 7'd2; fl_asn = 2'd0; fl_ppn = 7'h02; fl_perm = 3'b111;
    @(negedge clk);
    inv_all = 1'b0; fl_en = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    probe(7'd2, 2'd0, 2'b00);
    chk(lk_miss === 1'b1, "R10", "fill dropped", 32'(lk_miss), 32'd1);
    probe(7'd1, 2'd0, 2'b00);
    chk(lk_miss === 1'b1, "R10", "old cleared", 32'(lk_miss), 32'd1);

    // R8: lowest free first, then pointer (still 2) picks third fill
    for (int k = 0; k < N; k++) do_fill(7'(8'h10 + k), 2'd0, 7'(8'h48 + k), 3'b111);
    do_fill(7'h14, 2'd0, 7'h4c, 3'b011);
    probe(7'h12, 2'd0, 2'b00);
    chk(lk_miss === 1'b1, "R8", "third fill evicted", 32'(lk_miss), 32'd1);
    probe(7'h10, 2'd0, 2'b00);
    chk(lk_hit === 1'b1, "R8", "first fill kept", 32'(lk_hit), 32'd1);
    sweep("R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule